// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block sits behind a flash read path. It takes the three-byte Hamming code stored in the spare area next to each 512-byte sector and the code computed over the same sector as it streamed in, and decides whether the sector is clean, holds a single flipped data bit that can be repaired, or is beyond repair. When a repair is possible, the block reads the faulty byte from the sector buffer, inverts the addressed bit and writes the byte back. It also reports the page-relative byte offset and the bit index of the repair.

Each 24-bit code is presented already unpacked into parity bits. Bits [11:0] hold the even parities P1e..P2048e, with bit i carrying P(2^i)e. Bits [23:12] hold the odd parities P1o..P2048o in the same order. The caller pulses a start input with both code sets and a page-size select. A narrow page is one 512-byte sector using code slot 0. A wide page is 2048 bytes and is handled as four sub-sectors in order, where slot k occupies bits [24k+23:24k] and covers buffer bytes k*512 to k*512+511. One done pulse closes each page.

Top module: `ecc_corr`

## Requirements
- R1: When the stored and computed codes of a sub-sector are identical, that sub-sector is clean and the buffer is neither read nor written for it.
- R2: When the syndrome (stored XOR computed) has exactly 12 bits set, the sub-sector is correctable. The byte offset is syndrome bits [23:15] (P8o is the LSB) and the bit index is syndrome bits [14:12] (P1o is the LSB). The block reads that byte in one cycle and writes it back with only that bit inverted in the next cycle, at the same address.
- R3: A syndrome with exactly 1 or exactly 11 bits set is uncorrectable, and the buffer is not written.
- R4: Any other nonzero syndrome weight is uncorrectable. The one exception is a stored code of 24'hFFFFFF with a computed code of 24'h000000, which is treated as an erased sector and reported clean. The reverse pairing is not an exception.
- R5: With wideI=1, sub-sectors 0 to 3 are checked in order at buffer address k*512+offset. Processing stops after the first uncorrectable sub-sector, and later sub-sectors are not touched. With wideI=0, only slot 0 is used and the other slots are ignored.
- R6: statusO encodes 0 for clean, 1 for corrected and 2 for uncorrectable. Uncorrectable takes precedence over corrected, and corrected takes precedence over clean. errOffsetO and errBitO hold the page offset and bit index of the last repair made.
- R7: Every sub-sector takes exactly 3 cycles regardless of data. doneO is a one-cycle pulse, seen 3*n clock edges after the edge that samples startI, where n is the number of sub-sectors processed.
- R8: After reset, doneO, statusO, bufRdEnO and bufWrEnO are 0. startI is ignored while a page is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startI | input | 1 | Begin a page check (sampled when idle) |
| wideI | input | 1 | 1 = four sub-sectors, 0 = one sector |
| storedI | input | 96 | Codes read from the spare area, slot k at [24k+23:24k] |
| calcI | input | 96 | Codes computed over the data, same layout |
| bufRdEnO | output | 1 | Sector buffer read strobe |
| bufAddrO | output | 11 | Buffer byte address for read and write |
| bufRdDataI | input | 8 | Buffer read data, valid the cycle after bufRdEnO |
| bufWrEnO | output | 1 | Sector buffer write strobe |
| bufWrDataO | output | 8 | Repaired byte |
| doneO | output | 1 | One-cycle page-complete pulse |
| statusO | output | 2 | Page status (0 clean, 1 corrected, 2 uncorrectable) |
| errOffsetO | output | 11 | Page byte offset of the last repair |
| errBitO | output | 3 | Bit index of the last repair |

## Verification
The assertions check the buffer handshake on every cycle. A write must come exactly one cycle after a read of the same address, and every read must be followed by its write. They also check that done lasts one cycle, that the buffer is idle while done is high, and that the status never holds the unused code. The classification rule itself can only be shown by the bench scenarios. These cover the weight boundaries (1, 11, 12, 13, 16), the erased-sector exception and its reverse, the sub-sector addressing and early stop in wide mode, and the fixed cycle count per sub-sector.

// File: rtl/ecc_corr_pkg.sv
package ecc_corr_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_BAD   = 2'd2
  } eccStat_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCodes;
    logic clearAgg;
    logic classify;
    logic accumulate;
  } strobe_t;
endpackage

// File: rtl/ecc_corr_dp.sv
module ecc_corr_dp
  import ecc_corr_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SUBS         = 4,
  parameter int DATA_W       = 8
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  strobe_t                                   stb,
  input  logic [$clog2(SUBS)-1:0]                   subIdx,
  input  logic [SUBS*2*($clog2(SECTOR_BYTES)+$clog2(DATA_W))-1:0] storedI,
  input  logic [SUBS*2*($clog2(SECTOR_BYTES)+$clog2(DATA_W))-1:0] calcI,
  input  logic [DATA_W-1:0]                         bufRdDataI,
  output logic [$clog2(SECTOR_BYTES)+$clog2(SUBS)-1:0] bufAddrO,
  output logic [DATA_W-1:0]                         bufWrDataO,
  output eccStat_e                                  clsO,
  output eccStat_e                                  statusO,
  output logic [$clog2(SECTOR_BYTES)+$clog2(SUBS)-1:0] errOffsetO,
  output logic [$clog2(DATA_W)-1:0]                 errBitO
);
  localparam int OFFS_W  = $clog2(SECTOR_BYTES);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int HALF_W  = OFFS_W + BIT_W;
  localparam int CODE_W  = 2 * HALF_W;
  localparam int SUB_W   = $clog2(SUBS);
  localparam int PAGE_AW = OFFS_W + SUB_W;
  localparam int CNT_W   = $clog2(CODE_W + 1);

  logic [SUBS*CODE_W-1:0] storedQ, calcQ;
  logic [CODE_W-1:0]      curStored, curCalc, syndrome;
  logic [CNT_W-1:0]       weight;
  eccStat_e               clsNext, clsQ, statQ;
  logic [OFFS_W-1:0]      offQ;
  logic [BIT_W-1:0]       bitQ;
  logic [PAGE_AW-1:0]     errOffQ;
  logic [BIT_W-1:0]       errBitQ;

  function automatic logic [CNT_W-1:0] popCount(input logic [CODE_W-1:0] v);
    logic [CNT_W-1:0] sum;
    sum = '0;
    for (int i = 0; i < CODE_W; i++) sum = sum + CNT_W'(v[i]);
    return sum;
  endfunction

  assign curStored = storedQ[subIdx*CODE_W +: CODE_W];
  assign curCalc   = calcQ[subIdx*CODE_W +: CODE_W];
  assign syndrome  = curStored ^ curCalc;
  assign weight    = popCount(syndrome);

  always_comb begin
    if (syndrome == '0)
      clsNext = ST_CLEAN;
    else if (weight == CNT_W'(HALF_W))
      clsNext = ST_FIXED;
    else if (curStored == '1 && curCalc == '0)
      clsNext = ST_CLEAN;   // erased sector
    else
      clsNext = ST_BAD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedQ <= '0;
      calcQ   <= '0;
      clsQ    <= ST_CLEAN;
      offQ    <= '0;
      bitQ    <= '0;
      statQ   <= ST_CLEAN;
      errOffQ <= '0;
      errBitQ <= '0;
    end else begin
      if (stb.loadCodes) begin
        storedQ <= storedI;
        calcQ   <= calcI;
      end
      if (stb.classify) begin
        clsQ <= clsNext;
        offQ <= syndrome[CODE_W-1 -: OFFS_W];
        bitQ <= syndrome[HALF_W +: BIT_W];
      end
      if (stb.clearAgg) begin
        statQ   <= ST_CLEAN;
        errOffQ <= '0;
        errBitQ <= '0;
      end else if (stb.accumulate) begin
        if (clsQ == ST_BAD) begin
          statQ <= ST_BAD;
        end else if (clsQ == ST_FIXED) begin
          if (statQ != ST_BAD) statQ <= ST_FIXED;
          errOffQ <= {subIdx, offQ};
          errBitQ <= bitQ;
        end
      end
    end
  end

  assign bufAddrO   = {subIdx, offQ};
  assign bufWrDataO = bufRdDataI ^ (DATA_W'(1) << bitQ);
  assign clsO       = clsQ;
  assign statusO    = statQ;
  assign errOffsetO = errOffQ;
  assign errBitO    = errBitQ;
endmodule

// File: rtl/ecc_corr_ctrl.sv
module ecc_corr_ctrl
  import ecc_corr_pkg::*;
#(
  parameter int SUBS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startI,
  input  logic                    wideI,
  input  eccStat_e                clsI,
  output strobe_t                 stb,
  output logic [$clog2(SUBS)-1:0] subIdxO,
  output logic                    bufRdEnO,
  output logic                    bufWrEnO,
  output logic                    doneO
);
  localparam int SUB_W = $clog2(SUBS);

  typedef enum logic [2:0] {S_IDLE, S_CLASS, S_FETCH, S_PATCH, S_FIN} state_e;

  state_e            stateQ, stateNext;
  logic [SUB_W-1:0]  subQ;
  logic              wideQ;
  logic              lastSub;

  assign lastSub = !wideQ || (subQ == SUB_W'(SUBS - 1));

  always_comb begin
    stb       = '0;
    stateNext = stateQ;
    bufRdEnO  = 1'b0;
    bufWrEnO  = 1'b0;
    doneO     = 1'b0;
    unique case (stateQ)
      S_IDLE: if (startI) begin
        stb.loadCodes = 1'b1;
        stb.clearAgg  = 1'b1;
        stateNext     = S_CLASS;
      end
      S_CLASS: begin
        stb.classify = 1'b1;
        stateNext    = S_FETCH;
      end
      S_FETCH: begin
        bufRdEnO  = (clsI == ST_FIXED);
        stateNext = S_PATCH;
      end
      S_PATCH: begin
        bufWrEnO       = (clsI == ST_FIXED);
        stb.accumulate = 1'b1;
        stateNext      = (clsI == ST_BAD || lastSub) ? S_FIN : S_CLASS;
      end
      S_FIN: begin
        doneO     = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      subQ   <= '0;
      wideQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stateQ == S_IDLE && startI) begin
        subQ  <= '0;
        wideQ <= wideI;
      end else if (stateQ == S_PATCH && stateNext == S_CLASS) begin
        subQ <= subQ + SUB_W'(1);
      end
    end
  end

  assign subIdxO = subQ;
endmodule

// File: rtl/ecc_corr.sv
module ecc_corr
  import ecc_corr_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SUBS         = 4,
  parameter int DATA_W       = 8,
  localparam int OFFS_W  = $clog2(SECTOR_BYTES),
  localparam int BIT_W   = $clog2(DATA_W),
  localparam int CODE_W  = 2 * (OFFS_W + BIT_W),
  localparam int PAGE_AW = OFFS_W + $clog2(SUBS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startI,
  input  logic                     wideI,
  input  logic [SUBS*CODE_W-1:0]   storedI,
  input  logic [SUBS*CODE_W-1:0]   calcI,
  output logic                     bufRdEnO,
  output logic [PAGE_AW-1:0]       bufAddrO,
  input  logic [DATA_W-1:0]        bufRdDataI,
  output logic                     bufWrEnO,
  output logic [DATA_W-1:0]        bufWrDataO,
  output logic                     doneO,
  output logic [1:0]               statusO,
  output logic [PAGE_AW-1:0]       errOffsetO,
  output logic [BIT_W-1:0]         errBitO
);
  strobe_t                  stb;
  logic [$clog2(SUBS)-1:0]  subIdx;
  eccStat_e                 cls, stat;

  ecc_corr_ctrl #(.SUBS(SUBS)) ctrl_i (
    .clk(clk), .rstN(rstN), .startI(startI), .wideI(wideI), .clsI(cls),
    .stb(stb), .subIdxO(subIdx), .bufRdEnO(bufRdEnO), .bufWrEnO(bufWrEnO),
    .doneO(doneO)
  );

  ecc_corr_dp #(.SECTOR_BYTES(SECTOR_BYTES), .SUBS(SUBS), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .subIdx(subIdx),
    .storedI(storedI), .calcI(calcI), .bufRdDataI(bufRdDataI),
    .bufAddrO(bufAddrO), .bufWrDataO(bufWrDataO), .clsO(cls),
    .statusO(stat), .errOffsetO(errOffsetO), .errBitO(errBitO)
  );

  assign statusO = stat;
endmodule

// File: rtl/ecc_corr_chk.sv
module ecc_corr_chk #(
  parameter int PAGE_AW = 11
) (
  input logic               clk,
  input logic               rstN,
  input logic               bufRdEnO,
  input logic [PAGE_AW-1:0] bufAddrO,
  input logic               bufWrEnO,
  input logic               doneO,
  input logic [1:0]         statusO
);
  // R2: a write only follows a read of the same address one cycle earlier
  assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEnO |-> ($past(bufRdEnO) && $stable(bufAddrO)));

  // R2: every read of a faulty byte is followed by its write-back
  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEnO |=> bufWrEnO);

  // R7: done lasts exactly one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  // R8: no buffer traffic while the page completes
  assert_quiet_at_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (!bufRdEnO && !bufWrEnO));

  // R6: status never takes the unused encoding
  assert_status_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (statusO != 2'd3));
endmodule

bind ecc_corr ecc_corr_chk #(.PAGE_AW(PAGE_AW)) chk_i (
  .clk(clk), .rstN(rstN), .bufRdEnO(bufRdEnO), .bufAddrO(bufAddrO),
  .bufWrEnO(bufWrEnO), .doneO(doneO), .statusO(statusO)
);

// File: tb/ecc_corr_tb_top.sv
module ecc_corr_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic        wideI = 1'b0;
  logic [95:0] storedI = '0;
  logic [95:0] calcI = '0;
  logic        bufRdEnO, bufWrEnO, doneO;
  logic [10:0] bufAddrO, errOffsetO;
  logic [7:0]  bufRdDataI, bufWrDataO;
  logic [1:0]  statusO;
  logic [2:0]  errBitO;

  always #5 clk = ~clk;

  ecc_corr dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .wideI(wideI),
    .storedI(storedI), .calcI(calcI), .bufRdEnO(bufRdEnO), .bufAddrO(bufAddrO),
    .bufRdDataI(bufRdDataI), .bufWrEnO(bufWrEnO), .bufWrDataO(bufWrDataO),
    .doneO(doneO), .statusO(statusO), .errOffsetO(errOffsetO), .errBitO(errBitO)
  );

  // sector buffer model
  logic [7:0] mem [2048];
  logic       clearReq = 1'b0;
  int         wrCnt = 0;
  int         doneCnt = 0;

  function automatic logic [7:0] patt(input int a);
    return 8'(a * 37 + 11);
  endfunction

  always @(posedge clk) begin
    if (clearReq) begin
      for (int i = 0; i < 2048; i++) mem[i] <= patt(i);
      wrCnt   <= 0;
      doneCnt <= 0;
    end else begin
      if (bufRdEnO) bufRdDataI <= mem[bufAddrO];
      if (bufWrEnO) begin
        mem[bufAddrO] <= bufWrDataO;
        wrCnt <= wrCnt + 1;
      end
      if (doneO) doneCnt <= doneCnt + 1;
    end
  end

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks = nChecks + 1;
      nFails  = nFails + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // run one page; poke=1 pulses start again while busy
  task automatic runPage(input logic wide, input logic [95:0] st,
                         input logic [95:0] ca, input logic poke, output int cyc);
    @(negedge clk); clearReq = 1'b1;
    @(negedge clk); clearReq = 1'b0;
    wideI = wide; storedI = st; calcI = ca; startI = 1'b1;
    @(posedge clk);
    @(negedge clk); startI = 1'b0;
    cyc = 0;
    while (!doneO && cyc < 100) begin
      startI = (poke && cyc == 2);
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    startI = 1'b0;
  endtask

  typedef struct packed {
    logic [23:0] stored;
    logic [23:0] syn;
    logic [1:0]  expStat;
    logic [8:0]  expOff;
    logic [2:0]  expBit;
  } vec_t;

  localparam vec_t VECS [12] = '{
    {24'h123456, 24'h000000, 2'd0, 9'h000, 3'd0},  // R1 identical
    {24'h0F0F0F, 24'h52BAD4, 2'd1, 9'h0A5, 3'd3},  // R2 weight 12
    {24'hABCDEF, 24'h000FFF, 2'd1, 9'h000, 3'd0},  // R2 lowest address
    {24'h000000, 24'hFFF000, 2'd1, 9'h1FF, 3'd7},  // R2 highest address
    {24'h5A5A5A, 24'h000001, 2'd2, 9'h000, 3'd0},  // R3 weight 1
    {24'h5A5A5A, 24'h0007FF, 2'd2, 9'h000, 3'd0},  // R3 weight 11
    {24'h777777, 24'h000003, 2'd2, 9'h000, 3'd0},  // R4 weight 2
    {24'h777777, 24'h00FFFF, 2'd2, 9'h000, 3'd0},  // R4 weight 16
    {24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'h000, 3'd0},  // R4 erased
    {24'hFFFFFF, 24'hFFFFFE, 2'd2, 9'h000, 3'd0},  // R4 near-erased
    {24'h000000, 24'hFFFFFF, 2'd2, 9'h000, 3'd0},  // R4 reverse pairing
    {24'h246802, 24'h001FFF, 2'd2, 9'h000, 3'd0}   // R4 weight 13
  };

  initial begin
    int cyc;
    logic [95:0] st, ca;

    // reset state (R8)
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset done", int'(doneO), 0);
    check("R8 reset status", int'(statusO), 0);
    check("R8 reset rd", int'(bufRdEnO), 0);
    check("R8 reset wr", int'(bufWrEnO), 0);

    // narrow-page vector table
    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      runPage(1'b0, {72'h0, v.stored}, {72'h0, v.stored ^ v.syn}, 1'b0, cyc);
      check("R7 narrow cycles", cyc, 3);
      check("R6 status", int'(statusO), int'(v.expStat));
      if (v.expStat == 2'd1) begin
        check("R2 offset", int'(errOffsetO), int'(v.expOff));
        check("R2 bit", int'(errBitO), int'(v.expBit));
        check("R2 repaired byte", int'(mem[int'(v.expOff)]),
              int'(patt(int'(v.expOff)) ^ (8'd1 << v.expBit)));
        check("R2 one write", wrCnt, 1);
      end else begin
        check("R1 R3 no write", wrCnt, 0);
      end
    end

    // wide page, two repairs (R5, R6)
    st = {24'h444444, 24'h333333, 24'h222222, 24'h111111};
    ca = st ^ {24'h000000, 24'h8067F9, 24'h029FD6, 24'h000000};
    runPage(1'b1, st, ca, 1'b0, cyc);
    check("R7 wide cycles", cyc, 12);
    check("R6 wide status", int'(statusO), 1);
    check("R6 last offset", int'(errOffsetO), 'h500);
    check("R6 last bit", int'(errBitO), 6);
    check("R5 sub1 repair", int'(mem['h205]), int'(patt('h205) ^ 8'h02));
    check("R5 sub2 repair", int'(mem['h500]), int'(patt('h500) ^ 8'h40));
    check("R5 two writes", wrCnt, 2);

    // wide page, stop at first uncorrectable (R5)
    ca = st ^ {24'h000000, 24'h018FE7, 24'h000001, 24'h010FEF};
    runPage(1'b1, st, ca, 1'b0, cyc);
    check("R7 early stop cycles", cyc, 6);
    check("R6 uncorrectable wins", int'(statusO), 2);
    check("R5 sub0 repaired", int'(mem[2]), int'(patt(2) ^ 8'h01));
    check("R5 sub2 untouched", int'(mem['h403]), int'(patt('h403)));
    check("R5 one write", wrCnt, 1);

    // wide erased page (R4)
    runPage(1'b1, {4{24'hFFFFFF}}, 96'h0, 1'b0, cyc);
    check("R4 erased wide status", int'(statusO), 0);
    check("R7 erased wide cycles", cyc, 12);

    // narrow page ignores upper slots (R5)
    runPage(1'b0, st, st ^ {72'h0, 24'h000001} << 24, 1'b0, cyc);
    check("R5 narrow ignores slot1", int'(statusO), 0);
    check("R7 narrow cycles", cyc, 3);

    // start while busy is ignored (R8)
    runPage(1'b1, st, st, 1'b1, cyc);
    check("R8 busy start cycles", cyc, 12);
    repeat (20) @(negedge clk);
    check("R8 single done", doneCnt, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule